// File: doc/BRIEF.md
# Latched One-of-Eight Select Decoder with Acknowledge

This block turns a small binary address into a set of active-low select lines, exactly one of which goes low when the block is enabled. A level-sensitive address latch sits in front of the decoder. While the latch control is high, the selects follow the address inputs directly. When the latch control drops, the last address is held, so the address bus can move on without disturbing the selection.

Three enable terms gate the selects: one active-low term and a pair of active-high terms. An acknowledge line works like an open-drain signal. It is driven low only while the block is enabled and a read or write strobe is low. At all other times it is released, and an external pull-up makes it read high. The acknowledge is brought out as a value plus an output-enable so that the pull-up can be modelled outside the block. All paths are combinational from the latch contents and the enable and strobe inputs; no clock is used.

Top module: `latched_sel_decoder`

## Requirements
- R1: While `addr_le` is 1, the latch is transparent, and the selected output index tracks `addr_in` with no clock.
- R2: While `addr_le` is 0, the address captured when it fell is held. Later changes on `addr_in` do not change `sel_n`.
- R3: The block is enabled only when `en_n` is 0 and both bits of `en_hi` are 1. Any other value of either term disables it.
- R4: While disabled, `sel_n` is all ones (8'hFF), whatever the latched address.
- R5: While enabled, exactly one bit of `sel_n` is 0, and its index equals the latched address. Address 0 gives 8'hFE and address 7 gives 8'h7F.
- R6: While enabled with `rd_n` or `wr_n` (or both) at 0, `ack_oe` is 1 and `ack_n` is 0, so the line reads low.
- R7: While disabled, or while both strobes are 1, `ack_oe` is 0, so the line is released and the pull-up makes it read 1.
- R8: Removing any enable term while a strobe is still low releases the acknowledge in the same evaluation, with no delay.
- R9: Disabling and re-enabling does not disturb the latched address. After re-enabling with `addr_le` at 0, the same output is selected as before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_in | input | 3 | Binary address to latch and decode |
| addr_le | input | 1 | Latch control: 1 = transparent, 0 = hold |
| en_n | input | 1 | Active-low enable term |
| en_hi | input | 2 | Active-high enable terms; both must be 1 |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| sel_n | output | 8 | One-hot active-low select lines |
| ack_n | output | 1 | Acknowledge drive value (always low when driven) |
| ack_oe | output | 1 | Acknowledge output-enable; 0 = released to pull-up |

## Verification
The hardest case to reach from the ports is the one where the latched address and the address on the bus differ. The latch must therefore be closed first, and the bus then moved to every other value while the block is enabled and disabled. The stimulus latches each of the eight addresses, drops `addr_le`, walks the bus through all the other codes, and checks that the held index does not move. It then removes and restores the enable and checks the same index again. The acknowledge is resolved through a modelled pull-up. It is exercised with every strobe pair and with each enable term withdrawn on its own while a strobe is held low.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
   typedef struct packed {
      logic en_n;
      logic [1:0] en_hi;
   } lsd_enable_t;

   function automatic logic lsd_is_enabled(input lsd_enable_t e);
      return (e.en_n == 1'b0) && (&e.en_hi);
   endfunction
endpackage

// File: rtl/lsd_addr_latch.sv
module lsd_addr_latch #(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] d_in,
   input  logic              open_lvl,
   output logic [ADDR_W-1:0] q_out
);
   if (ADDR_W < 1) begin : g_bad_w
      $error("lsd_addr_latch: ADDR_W must be at least 1");
   end

   always_latch begin
      if (open_lvl) q_out = d_in;
   end

   always_comb begin
      if (open_lvl) assert_transparent_R1: assert (q_out == d_in)
         else $error("latch not transparent");
   end
endmodule

// File: rtl/lsd_onehot_dec.sv
module lsd_onehot_dec #(
   parameter int ADDR_W = 3,
   localparam int NSEL = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] code,
   input  logic              active,
   output logic [NSEL-1:0]   line_n
);
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_w
      $error("lsd_onehot_dec: ADDR_W out of range");
   end

   for (genvar i = 0; i < NSEL; i++) begin : g_line
      assign line_n[i] = ~(active && (code == ADDR_W'(i)));
   end
endmodule

// File: rtl/lsd_ack_ctl.sv
module lsd_ack_ctl (
   input  logic active,
   input  logic rd_n,
   input  logic wr_n,
   output logic drv_n,
   output logic drv_oe
);
   assign drv_n  = 1'b0;
   assign drv_oe = active && !(rd_n && wr_n);
endmodule

// File: rtl/latched_sel_decoder.sv
module latched_sel_decoder
   import lsd_pkg::*;
#(
   parameter int ADDR_W = 3,
   localparam int NSEL = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              addr_le,
   input  logic              en_n,
   input  logic [1:0]        en_hi,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic [NSEL-1:0]   sel_n,
   output logic              ack_n,
   output logic              ack_oe
);
   lsd_enable_t en_s;
   logic        dev_en;
   logic [ADDR_W-1:0] lat_addr;

   assign en_s.en_n  = en_n;
   assign en_s.en_hi = en_hi;
   assign dev_en     = lsd_is_enabled(en_s);

   lsd_addr_latch #(.ADDR_W(ADDR_W)) i_latch (
      .d_in(addr_in), .open_lvl(addr_le), .q_out(lat_addr));

   lsd_onehot_dec #(.ADDR_W(ADDR_W)) i_dec (
      .code(lat_addr), .active(dev_en), .line_n(sel_n));

   lsd_ack_ctl i_ack (
      .active(dev_en), .rd_n(rd_n), .wr_n(wr_n),
      .drv_n(ack_n), .drv_oe(ack_oe));

   always_comb begin
      assert_at_most_one_R5: assert ($countones(~sel_n) <= 1)
         else $error("more than one select low");
      if (!dev_en) assert_idle_high_R4: assert (&sel_n)
         else $error("select low while disabled");
      if (dev_en) assert_index_R5: assert (sel_n[lat_addr] == 1'b0)
         else $error("wrong select index");
      if (ack_oe) assert_ack_cause_R7: assert (dev_en && !(rd_n && wr_n))
         else $error("acknowledge driven without cause");
      if (!en_n && (&en_hi) && !rd_n) assert_ack_drive_R6: assert (ack_oe && !ack_n)
         else $error("acknowledge not driven on read");
   end
endmodule

// File: tb/test_latched_sel_decoder.sv
module test_latched_sel_decoder;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [2:0] addr_in = 3'd0;
   logic       addr_le = 1'b1;
   logic       en_n = 1'b1;
   logic [1:0] en_hi = 2'b00;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] sel_n;
   logic       ack_n, ack_oe;
   logic       ack_line;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   assign ack_line = ack_oe ? ack_n : 1'b1;

   latched_sel_decoder i_latched_sel_decoder (
      .addr_in(addr_in), .addr_le(addr_le), .en_n(en_n), .en_hi(en_hi),
      .rd_n(rd_n), .wr_n(wr_n), .sel_n(sel_n), .ack_n(ack_n), .ack_oe(ack_oe));

   function automatic logic [7:0] exp_sel(input logic en, input int a);
      return en ? ~(8'd1 << a) : 8'hFF;
   endfunction

   task automatic chk8(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      settle();
      chk8("R4 reset state sel", sel_n, 8'hFF);
      chk8("R7 reset state ack", {7'd0, ack_line}, 8'd1);
      en_n = 1'b0; en_hi = 2'b11;
      for (int a = 0; a < 8; a++) begin
         addr_in = 3'(a); settle();
         chk8("R1 R5 transparent sweep", sel_n, exp_sel(1'b1, a));
      end
      for (int a = 0; a < 8; a++) begin
         addr_le = 1'b1; addr_in = 3'(a); settle();
         addr_le = 1'b0; settle();
         for (int b = 0; b < 8; b++) begin
            addr_in = 3'(b); settle();
            chk8("R2 held address", sel_n, exp_sel(1'b1, a));
         end
         en_n = 1'b1; addr_in = 3'(7 - a); settle();
         chk8("R4 disabled while held", sel_n, 8'hFF);
         en_n = 1'b0; settle();
         chk8("R9 re-enable keeps latch", sel_n, exp_sel(1'b1, a));
      end
      addr_le = 1'b1; addr_in = 3'd5; settle();
      for (int t = 0; t < 4; t++) begin
         en_n = (t == 0); en_hi = (t == 0) ? 2'b11 : 2'(t - 1);
         for (int s = 0; s < 4; s++) begin
            rd_n = s[0]; wr_n = s[1]; settle();
            chk8("R3 R4 enable term off", sel_n, 8'hFF);
            chk8("R7 ack released when disabled", {7'd0, ack_line}, 8'd1);
         end
      end
      en_n = 1'b0; en_hi = 2'b11;
      for (int s = 0; s < 4; s++) begin
         rd_n = s[0]; wr_n = s[1]; settle();
         chk8("R3 enabled select", sel_n, exp_sel(1'b1, 5));
         chk8("R6 R7 strobe combos", {7'd0, ack_line}, {7'd0, (s == 3)});
      end
      for (int t = 0; t < 4; t++) begin
         en_n = 1'b0; en_hi = 2'b11; rd_n = t[0]; wr_n = !t[0]; settle();
         chk8("R6 ack before drop", {7'd0, ack_line}, 8'd0);
         if (t == 0) en_n = 1'b1; else en_hi = 2'(t - 1);
         #1;
         chk8("R8 ack released at once", {7'd0, ack_oe}, 8'd0);
      end
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog got=hung exp=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule